// File: doc/BRIEF.md
# Clocked serial transceiver

A full-duplex byte shifter for a point-to-point serial link with one clock line and one data line in each direction. Three registers work apart from each other: a transmit holding buffer, a shift register and a receive holding buffer. Software can therefore queue the next byte and collect the previous one while the current byte is still moving. In master mode the block makes the serial clock from the system clock, with a programmable divider. In slave mode it follows a clock from outside, first bringing that clock into the system clock domain.

The clock line idles high. The outgoing bit changes on each falling serial-clock edge, and the incoming bit is sampled on each rising edge. The bit order can be set to most-significant first or least-significant first. Four status events drive one level interrupt through a per-event enable mask: transmit buffer empty, transmit end, receive full and overrun.

Top module: `sxr_xcvr`

## Requirements
- R1: After reset: `st_tx_empty`=1, `st_tx_end`=0, `st_rx_full`=0, `st_overrun`=0, `sck_o`=1, `sd_o`=1.
- R2: With `cfg_master`=1, `sck_oe`=1. Each high and low phase of `sck_o` inside a transfer lasts `cfg_div`+1 system clock cycles. `sck_o` stays high while the link is idle.
- R3: With `cfg_lsb_first`=0, bit 7 of the byte goes out first and the first bit received lands in bit 7. With `cfg_lsb_first`=1, bit 0 goes out first and the first bit received lands in bit 0. `sd_o` changes after a falling edge, and `sd_i` is sampled at a rising edge.
- R4: A `tx_wr` pulse loads `tx_data` only while `st_tx_empty`=1. A write while the buffer is full is dropped and its byte is never sent. `st_tx_empty` returns to 1 when the buffer moves into the shift register at the first falling edge of a byte.
- R5: If a byte is queued before the current byte finishes, the next byte follows without a pause. The first falling edge of the next byte comes `cfg_div`+1 cycles after the last rising edge of the current byte.
- R6: `st_tx_end` is set when the last bit of a byte has been sampled and no byte is queued. A `tx_wr` pulse clears it.
- R7: At the end of a byte, the received value goes to `rx_data` and `st_rx_full` is set. A `rx_rd` pulse clears `st_rx_full`.
- R8: If a byte completes while `st_rx_full`=1, `st_overrun` is set, `rx_data` keeps the unread byte and the new byte is discarded. `st_overrun` stays set until a `ovr_clr` pulse.
- R9: With `cfg_master`=0, `sck_oe`=0 and the block shifts on edges of `sck_i`. If no byte is queued when a slave byte starts, all ones are sent.
- R10: `irq` is the OR of the enabled flags. Enable bit 0 selects `st_tx_empty`, bit 1 `st_tx_end`, bit 2 `st_rx_full` and bit 3 `st_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate the serial clock, 0: follow `sck_i` |
| cfg_lsb_first | input | 1 | 1: least-significant bit first |
| cfg_div | input | DIV_W | Half-period of the master clock, minus one, in system cycles |
| irq_en | input | 4 | Per-flag interrupt enables |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | DATA_W | Byte to queue |
| rx_rd | input | 1 | Read-acknowledge strobe, clears receive full |
| rx_data | output | DATA_W | Last accepted received byte |
| ovr_clr | input | 1 | Clears the overrun flag |
| st_tx_empty | output | 1 | Transmit buffer can accept a byte |
| st_tx_end | output | 1 | Transmission finished with nothing queued |
| st_rx_full | output | 1 | Unread byte in `rx_data` |
| st_overrun | output | 1 | A byte was lost to an unread buffer |
| irq | output | 1 | Combined interrupt |
| sck_i | input | 1 | External serial clock (slave mode) |
| sck_o | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Output enable for the serial clock pad |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |

## Verification
The properties take for granted that the mode, bit order and divider stay fixed while a byte is in flight. They also take for granted that each external clock phase lasts several system cycles, so that the synchroniser sees every edge. The bench changes configuration only when the link is idle. It drives slave clock phases of six system cycles and holds `sd_i` steady across each rising edge. In master mode it loops `sd_o` back to `sd_i`, so the expected received byte equals the byte that was sent.

// File: rtl/sxr_pkg.sv
package sxr_pkg;
    // positions of the status flags inside the interrupt enable mask
    localparam int FLG_TXE  = 0;
    localparam int FLG_TEND = 1;
    localparam int FLG_RXF  = 2;
    localparam int FLG_OVR  = 3;
    localparam int FLG_N    = 4;
endpackage

// File: rtl/sxr_sck_gen.sv
module sxr_sck_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             fall_ev,
    output logic             rise_ev
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
    } gen_t;

    gen_t g_d, g_q;
    logic expire;

    always_comb begin
        g_d    = g_q;
        expire = run && (g_q.cnt == div);
        if (!run) begin
            g_d.cnt = '0;
            g_d.sck = 1'b1;
        end else if (expire) begin
            g_d.cnt = '0;
            g_d.sck = ~g_q.sck;
        end else begin
            g_d.cnt = g_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{cnt: '0, sck: 1'b1};
        end else begin
            g_q <= g_d;
        end
    end

    assign sck     = g_q.sck;
    assign fall_ev = expire && g_q.sck;
    assign rise_ev = expire && !g_q.sck;
endmodule

// File: rtl/sxr_sck_sync.sv
module sxr_sck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    output logic fall_ev,
    output logic rise_ev
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sy_d, sy_q;

    always_comb begin
        sy_d = {sy_q[W-2:0], sck_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign rise_ev = sy_q[W-2] & ~sy_q[W-1];
    assign fall_ev = ~sy_q[W-2] & sy_q[W-1];
endmodule

// File: rtl/sxr_xcvr.sv
module sxr_xcvr
    import sxr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_lsb_first,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [FLG_N-1:0]  irq_en,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    input  logic              ovr_clr,
    output logic              st_tx_empty,
    output logic              st_tx_end,
    output logic              st_rx_full,
    output logic              st_overrun,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sd_i,
    output logic              sd_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] txbuf;
        logic              tx_empty;
        logic              tx_end;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] rxbuf;
        logic              rx_full;
        logic              ovr;
        logic              run;
        logic              sdo;
    } xs_t;

    xs_t x_d, x_q;

    logic m_sck, m_fall, m_rise, s_fall, s_rise, fall_ev, rise_ev;
    logic [DATA_W-1:0] out_w, in_w;
    logic [FLG_N-1:0]  flags;

    sxr_sck_gen #(.DIV_W(DIV_W)) gen_i (
        .clk(clk), .rst_n(rst_n), .run(x_q.run), .div(cfg_div),
        .sck(m_sck), .fall_ev(m_fall), .rise_ev(m_rise)
    );

    sxr_sck_sync #(.STAGES(SYNC_N)) sync_i (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_i),
        .fall_ev(s_fall), .rise_ev(s_rise)
    );

    assign fall_ev = cfg_master ? m_fall : s_fall;
    assign rise_ev = cfg_master ? m_rise : s_rise;

    always_comb begin
        x_d   = x_q;
        out_w = x_q.sh;
        in_w  = cfg_lsb_first ? {sd_i, x_q.sh[DATA_W-1:1]}
                              : {x_q.sh[DATA_W-2:0], sd_i};

        if (rx_rd)   x_d.rx_full = 1'b0;
        if (ovr_clr) x_d.ovr     = 1'b0;

        if (tx_wr && x_q.tx_empty) begin
            x_d.txbuf    = tx_data;
            x_d.tx_empty = 1'b0;
            x_d.tx_end   = 1'b0;
        end

        // master starts only from a fully idle shifter with a byte queued
        if (!cfg_master) begin
            x_d.run = 1'b0;
        end else if (!x_q.run && !x_q.tx_empty && x_q.bitcnt == '0) begin
            x_d.run = 1'b1;
        end

        if (fall_ev) begin
            if (x_q.bitcnt == '0) begin
                if (!x_q.tx_empty) begin
                    out_w        = x_q.txbuf;
                    x_d.tx_empty = 1'b1;
                end else begin
                    out_w = '1;
                end
            end
            x_d.sh  = out_w;
            x_d.sdo = cfg_lsb_first ? out_w[0] : out_w[DATA_W-1];
        end

        if (rise_ev) begin
            x_d.sh = in_w;
            if (x_q.bitcnt == LAST_BIT) begin
                x_d.bitcnt = '0;
                if (x_q.rx_full && !rx_rd) begin
                    x_d.ovr = 1'b1;
                end else begin
                    x_d.rxbuf   = in_w;
                    x_d.rx_full = 1'b1;
                end
                if (x_q.tx_empty && !tx_wr) begin
                    x_d.tx_end = 1'b1;
                    x_d.run    = 1'b0;
                end
            end else begin
                x_d.bitcnt = x_q.bitcnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '{txbuf: '0, tx_empty: 1'b1, tx_end: 1'b0, sh: '0,
                     bitcnt: '0, rxbuf: '0, rx_full: 1'b0, ovr: 1'b0,
                     run: 1'b0, sdo: 1'b1};
        end else begin
            x_q <= x_d;
        end
    end

    always_comb begin
        flags           = '0;
        flags[FLG_TXE]  = x_q.tx_empty;
        flags[FLG_TEND] = x_q.tx_end;
        flags[FLG_RXF]  = x_q.rx_full;
        flags[FLG_OVR]  = x_q.ovr;
    end

    assign irq         = |(flags & irq_en);
    assign rx_data     = x_q.rxbuf;
    assign st_tx_empty = x_q.tx_empty;
    assign st_tx_end   = x_q.tx_end;
    assign st_rx_full  = x_q.rx_full;
    assign st_overrun  = x_q.ovr;
    assign sck_o       = cfg_master ? m_sck : 1'b1;
    assign sck_oe      = cfg_master;
    assign sd_o        = x_q.sdo;
endmodule

// File: rtl/sxr_xcvr_chk.sv
module sxr_xcvr_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_master,
    input logic              tx_wr,
    input logic              ovr_clr,
    input logic [DATA_W-1:0] rx_data,
    input logic              st_tx_end,
    input logic              st_rx_full,
    input logic              st_overrun,
    input logic              sck_o
);
    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overrun && !ovr_clr) |=> st_overrun);

    // R8
    ovr_keeps_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_overrun) |-> $stable(rx_data));

    // R6
    txend_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_tx_end) |-> $past(tx_wr));

    // R2
    idle_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && st_tx_end) |-> sck_o);

    // R7
    rx_update_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> st_rx_full);
endmodule

bind sxr_xcvr sxr_xcvr_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/sxr_xcvr_tb_top.sv
module sxr_xcvr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1, cfg_lsb_first = 1'b0;
    logic [3:0] cfg_div = 4'd0;
    logic [3:0] irq_en = 4'd0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic [7:0] rx_data;
    logic       st_tx_empty, st_tx_end, st_rx_full, st_overrun, irq;
    logic       sck_o, sck_oe, sd_o, sd_i;
    logic       sck_drv = 1'b1, sd_drv = 1'b1, loop_en = 1'b1;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    // monitor state
    logic [7:0] cap = 8'd0;
    int  mbits = 0, hp_cnt = 0, hp_err = 0;
    bit  cont_chk = 1'b0;
    logic sck_prev = 1'b1;

    always #2.5 clk = ~clk;

    assign sd_i = loop_en ? sd_o : sd_drv;

    sxr_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
        .cfg_lsb_first(cfg_lsb_first), .cfg_div(cfg_div), .irq_en(irq_en),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .ovr_clr(ovr_clr), .st_tx_empty(st_tx_empty), .st_tx_end(st_tx_end),
        .st_rx_full(st_rx_full), .st_overrun(st_overrun), .irq(irq),
        .sck_i(sck_drv), .sck_o(sck_o), .sck_oe(sck_oe), .sd_i(sd_i),
        .sd_o(sd_o)
    );

    // wire-order capture of sd_o at each rising sck_o, plus phase lengths
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_o !== sck_prev) begin
                if (sck_o === 1'b1 || (mbits % 8) != 0 || (cont_chk && mbits != 0)) begin
                    if (hp_cnt + 1 != int'(cfg_div) + 1) hp_err = hp_err + 1;
                end
                if (sck_o === 1'b1) begin
                    cap   = {cap[6:0], sd_o};
                    mbits = mbits + 1;
                end
                hp_cnt = 0;
            end else begin
                hp_cnt = hp_cnt + 1;
            end
            sck_prev = sck_o;
        end
    end

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_tx(input logic [7:0] b);
        @(negedge clk);
        tx_data = b;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr   = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_rx_full();
        for (int i = 0; i < 4000 && st_rx_full !== 1'b1; i++) @(negedge clk);
    endtask

    task automatic wait_tx_end();
        for (int i = 0; i < 4000 && st_tx_end !== 1'b1; i++) @(negedge clk);
    endtask

    task automatic slave_byte(input logic [7:0] w, output logic [7:0] got);
        got = 8'd0;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sck_drv = 1'b0;
            sd_drv  = w[i];
            cyc(6);
            got     = {got[6:0], sd_o};
            sck_drv = 1'b1;
            cyc(6);
        end
        cyc(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b, got;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk("R1 tx_empty", st_tx_empty, 1);
        chk("R1 tx_end", st_tx_end, 0);
        chk("R1 rx_full", st_rx_full, 0);
        chk("R1 overrun", st_overrun, 0);
        chk("R1 sck_o", sck_o, 1);
        chk("R1 sd_o", sd_o, 1);
        irq_en = 4'b1110;
        cyc(1);
        chk("R10 irq masked flags", irq, 0);
        irq_en = 4'b0000;

        // R2 R3 R6 R7 sweep over divider, bit order and data
        for (int dv = 0; dv < 4; dv++) begin
            for (int lf = 0; lf < 2; lf++) begin
                for (int k = 0; k < 6; k++) begin
                    cfg_div       = 4'(dv);
                    cfg_lsb_first = lf[0];
                    b = 8'((dv * 37 + lf * 91 + k * 53 + 5) & 255);
                    cyc(1);
                    cap = 8'd0; mbits = 0; hp_err = 0;
                    write_tx(b);
                    wait_rx_full();
                    cyc(1);
                    chk("R7 rx byte", rx_data, b);
                    chk("R3 wire order", cap, lf ? rev8(b) : b);
                    chk("R2 half period", hp_err, 0);
                    chk("R2 sck_oe", sck_oe, 1);
                    chk("R6 tx_end set", st_tx_end, 1);
                    chk("R2 idle high", sck_o, 1);
                    read_rx();
                    chk("R7 rx_full cleared", st_rx_full, 0);
                end
            end
        end

        // R5 back-to-back bytes
        cfg_div = 4'd1; cfg_lsb_first = 1'b0;
        cyc(2);
        mbits = 0; hp_err = 0; cont_chk = 1'b1;
        write_tx(8'h6B);
        for (int i = 0; i < 100 && st_tx_empty !== 1'b1; i++) @(negedge clk);
        write_tx(8'hD2);
        wait_rx_full();
        chk("R5 first byte", rx_data, 8'h6B);
        chk("R6 no tx_end while queued", st_tx_end, 0);
        read_rx();
        wait_rx_full();
        cyc(1);
        chk("R5 second byte", rx_data, 8'hD2);
        chk("R5 no gap", hp_err, 0);
        chk("R5 no overrun", st_overrun, 0);
        chk("R5 bit count", mbits, 16);
        read_rx();
        cont_chk = 1'b0;

        // R8 overrun keeps the unread byte
        cfg_div = 4'd0;
        write_tx(8'hA5);
        wait_rx_full();
        write_tx(8'h3C);
        wait_tx_end();
        cyc(1);
        chk("R8 overrun set", st_overrun, 1);
        chk("R8 old byte kept", rx_data, 8'hA5);
        for (int i = 0; i < 4; i++) begin
            irq_en = 4'(1 << i);
            cyc(1);
            chk("R10 single enable", irq, 1);
        end
        irq_en = 4'd0;
        read_rx();
        chk("R8 sticky after read", st_overrun, 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk("R8 cleared", st_overrun, 0);
        irq_en = 4'b1100;
        cyc(1);
        chk("R10 rx/ovr clear", irq, 0);
        irq_en = 4'b0011;
        cyc(1);
        chk("R10 tx flags", irq, 1);
        irq_en = 4'd0;

        // R9 R4 slave mode
        cfg_master = 1'b0; loop_en = 1'b0; cfg_lsb_first = 1'b0;
        cyc(2);
        chk("R9 sck_oe", sck_oe, 0);
        write_tx(8'h96);
        chk("R6 tx_end cleared by write", st_tx_end, 0);
        write_tx(8'h11);
        slave_byte(8'h5A, got);
        chk("R4 queued byte sent", got, 8'h96);
        chk("R9 rx slave", rx_data, 8'h5A);
        read_rx();
        slave_byte(8'hC3, got);
        chk("R4 R9 dropped write not sent, ones", got, 8'hFF);
        chk("R9 rx slave 2", rx_data, 8'hC3);
        chk("R6 tx_end slave", st_tx_end, 1);
        read_rx();
        cfg_lsb_first = 1'b1;
        write_tx(8'h01);
        slave_byte(8'h80, got);
        chk("R3 slave lsb out", got, 8'h80);
        chk("R3 slave lsb in", rx_data, 8'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule